// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Sign-Change Shift Overflow

This block is the execute-stage arithmetic and logic unit of a small 32-bit processor core. Each cycle the decoder may present a 4-bit operation code, operand A (the destination register's current value) and operand B (an already formed register-plus-immediate or immediate value). One clock edge later the block returns the result, an enable saying whether the result goes to the register file, an enable saying whether the condition flags are updated, and the four flags zero, carry, negative and overflow.

Operations are split by what they commit. Compare and bit-test are subtraction and AND that only touch the flags. The register-move, full and half load-immediate and rotate operations only write a result. The arithmetic, logic and shift operations in the upper half of the opcode space do both. Logical shifts report overflow whenever the shift flips the sign bit, so a conditional branch on overflow can catch a shift that lost the sign of the value.

Top module: `shift_ovf_alu`

## Requirements
- R1: Outputs are registered one cycle after the inputs: `out_valid` is high exactly in the cycle after `in_valid` was high, and synchronous reset clears `out_valid`, `wr_en` and `flag_en`.
- R2: Opcode 0 (compare) and opcode 1 (bit-test) raise `flag_en` and never `wr_en`; opcodes 2 (move), 3 (load-immediate), 4 (half load) and 5 (rotate) raise `wr_en` and never `flag_en`; opcodes 8 to 15 raise both; opcodes 6 and 7 raise neither.
- R3: Opcodes 0 and 8 compute A minus B; carry is the unsigned borrow (A < B) and overflow is set when the signed difference wraps, so 0x80000000 minus 1 sets overflow. Opcode 10 computes A plus B with carry-out and signed overflow.
- R4: Opcode 1 and opcode 9 compute A AND B, opcode 11 A OR B, opcode 12 A XOR B; all of them clear carry and overflow.
- R5: For every flag-updating operation, zero is set when the 32-bit result is all zeros and negative equals result bit 31.
- R6: Opcode 13 shifts A left and opcode 14 shifts A right, both logically, by B[5:0]; amounts of 32 or more give zero. Carry is the last bit shifted out (0 once the amount exceeds 32) and overflow is set when result bit 31 differs from A bit 31.
- R7: A shift amount of 0 returns A unchanged and clears carry and overflow.
- R8: Opcode 5 rotates A left by B[4:0] only; a rotate by 16 swaps the two 16-bit halves.
- R9: Opcode 3 writes B[23:0] sign-extended to 32 bits.
- R10: Opcode 4 replaces one 16-bit half of A with B[15:0] and keeps the other half: B[20]=1 replaces bits 31:16, B[20]=0 replaces bits 15:0.
- R11: Opcode 2 writes B unchanged; opcode 15 is an arithmetic right shift by B[5:0] with carry as the last bit out and overflow always clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A, destination register value |
| opb | input | 32 | Operand B, formed register-plus-immediate or immediate |
| out_valid | output | 1 | Result and enables below belong to an operation |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Write `result` to the destination register |
| flag_en | output | 1 | Update the condition flags from the four flag outputs |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / last bit shifted out |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest corners are the shift overflow cases, because they only appear when operand A sits exactly on the sign boundary: 0x40000000 and 0x80000000 shifted by one, together with amounts of 0, 32 and above 32, where carry changes its source. Directed tasks place these exact operands on the ports, and a random phase biases a share of operand A values toward the top two bits and shift amounts toward 0, 1, 31, 32 and 33, comparing each result with a bit-serial reference model in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_CMP    = 4'h0,
        OP_BTST   = 4'h1,
        OP_MOV    = 4'h2,
        OP_LDI    = 4'h3,
        OP_LDHALF = 4'h4,
        OP_ROL    = 4'h5,
        OP_RSV6   = 4'h6,
        OP_RSV7   = 4'h7,
        OP_SUB    = 4'h8,
        OP_AND    = 4'h9,
        OP_ADD    = 4'hA,
        OP_OR     = 4'hB,
        OP_XOR    = 4'hC,
        OP_LSL    = 4'hD,
        OP_LSR    = 4'hE,
        OP_ASR    = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } alu_flags_t;

    function automatic logic op_writes(alu_op_e o);
        return !(o == OP_CMP || o == OP_BTST || o == OP_RSV6 || o == OP_RSV7);
    endfunction

    function automatic logic op_flags(alu_op_e o);
        return (o == OP_CMP) || (o == OP_BTST) || o[3];
    endfunction

    function automatic shift_kind_e shift_kind(alu_op_e o);
        case (o)
            OP_LSL:  return SH_LEFT;
            OP_ASR:  return SH_ARITH;
            default: return SH_RIGHT;
        endcase
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v
);
    logic [W:0] wide;

    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0];
        c = wide[W];
        if (sub) v = (a[W-1] ^ b[W-1]) & (wide[W-1] ^ a[W-1]);
        else     v = ~(a[W-1] ^ b[W-1]) & (wide[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W) + 1
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  shift_kind_e    kind,
    output logic [W-1:0]   r,
    output logic           c,
    output logic           v
);
    logic [W:0]        left_x;
    logic [W:0]        right_x;
    logic signed [W:0] arith_in;
    logic signed [W:0] arith_x;

    always_comb begin
        left_x   = {1'b0, a} << amt;
        right_x  = {a, 1'b0} >> amt;
        arith_in = {a, 1'b0};
        arith_x  = arith_in >>> amt;
        case (kind)
            SH_LEFT: begin
                r = left_x[W-1:0];
                c = left_x[W];
            end
            SH_ARITH: begin
                r = arith_x[W:1];
                c = (amt == '0) ? 1'b0 : arith_x[0];
            end
            default: begin
                r = right_x[W:1];
                c = right_x[0];
            end
        endcase
        v = (amt != '0) && (r[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
    parameter int W = 32,
    localparam int RW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [RW-1:0] amt,
    output logic [W-1:0]  r
);
    logic [2*W-1:0] doubled;

    always_comb begin
        doubled = {a, a} << amt;
        r       = doubled[2*W-1:W];
    end
endmodule

// File: rtl/shift_ovf_alu.sv
module shift_ovf_alu
    import alu_pkg::*;
#(
    parameter int W            = 32,
    parameter int IMM_W        = 24,
    parameter int HALF_SEL_BIT = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         flag_en,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_v
);
    localparam int HALF = W / 2;
    localparam int SHW  = $clog2(W) + 1;
    localparam int RW   = $clog2(W);

    alu_op_e    op_e;
    logic [W-1:0] as_r, sh_r, rot_r;
    logic         as_c, as_v, sh_c, sh_v;
    logic [W-1:0] nxt_r;
    alu_flags_t   nxt_f;

    assign op_e = alu_op_e'(op);

    alu_addsub #(.W(W)) u_addsub (
        .a(opa), .b(opb), .sub(op_e != OP_ADD),
        .r(as_r), .c(as_c), .v(as_v)
    );

    alu_shift #(.W(W)) u_shift (
        .a(opa), .amt(opb[SHW-1:0]), .kind(shift_kind(op_e)),
        .r(sh_r), .c(sh_c), .v(sh_v)
    );

    alu_rotate #(.W(W)) u_rotate (
        .a(opa), .amt(opb[RW-1:0]), .r(rot_r)
    );

    always_comb begin
        nxt_r   = '0;
        nxt_f.c = 1'b0;
        nxt_f.v = 1'b0;
        case (op_e)
            OP_CMP, OP_SUB, OP_ADD: begin
                nxt_r   = as_r;
                nxt_f.c = as_c;
                nxt_f.v = as_v;
            end
            OP_BTST, OP_AND: nxt_r = opa & opb;
            OP_OR:           nxt_r = opa | opb;
            OP_XOR:          nxt_r = opa ^ opb;
            OP_MOV:          nxt_r = opb;
            OP_LDI:          nxt_r = {{(W-IMM_W){opb[IMM_W-1]}}, opb[IMM_W-1:0]};
            OP_LDHALF: begin
                if (opb[HALF_SEL_BIT]) nxt_r = {opb[HALF-1:0], opa[HALF-1:0]};
                else                   nxt_r = {opa[W-1:HALF], opb[HALF-1:0]};
            end
            OP_ROL:          nxt_r = rot_r;
            OP_LSL, OP_LSR, OP_ASR: begin
                nxt_r   = sh_r;
                nxt_f.c = sh_c;
                nxt_f.v = sh_v;
            end
            default:         nxt_r = '0;
        endcase
        nxt_f.z = (nxt_r == '0);
        nxt_f.n = nxt_r[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            flag_en   <= 1'b0;
            result    <= '0;
            {flag_z, flag_c, flag_n, flag_v} <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && op_writes(op_e);
            flag_en   <= in_valid && op_flags(op_e);
            result    <= nxt_r;
            {flag_z, flag_c, flag_n, flag_v} <= nxt_f;
        end
    end

    // R1: no operation in, nothing out next cycle
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !wr_en && !flag_en);

    // R2: compare and bit-test touch flags only
    a_r2_flags_only: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op == 4'h0 || op == 4'h1) |=> out_valid && !wr_en && flag_en);

    // R2: move, loads and rotate leave flags alone
    a_r2_write_only: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op == 4'h2 || op == 4'h3 || op == 4'h4 || op == 4'h5)
        |=> wr_en && !flag_en);

    // R6: logical right shift reports a sign change as overflow
    a_r6_lsr_sign: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 4'hE && opb[SHW-1:0] != '0
        |=> flag_v == (result[W-1] ^ $past(opa[W-1])));

    // R7: zero-distance shift is a pass-through with clear carry/overflow
    a_r7_zero_shift: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op == 4'hD || op == 4'hE) && opb[SHW-1:0] == '0
        |=> result == $past(opa) && !flag_c && !flag_v);

    // R8: rotate by a multiple of W is the identity
    a_r8_rol_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 4'h5 && opb[RW-1:0] == '0 |=> result == $past(opa));

    // R10: half load keeps the untouched half of A
    a_r10_half_keep: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 4'h4
        |=> (($past(opb[HALF_SEL_BIT]) && result[HALF-1:0] == $past(opa[HALF-1:0])) ||
             (!$past(opb[HALF_SEL_BIT]) && result[W-1:HALF] == $past(opa[W-1:HALF]))));
endmodule

// File: tb/shift_ovf_alu_tb.sv
`timescale 1ns/1ps
module shift_ovf_alu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid, wr_en, flag_en, flag_z, flag_c, flag_n, flag_v;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct packed {
        logic        wr;
        logic        fe;
        logic        z;
        logic        c;
        logic        n;
        logic        v;
        logic [31:0] r;
    } exp_t;

    always #5 clk = ~clk;

    shift_ovf_alu u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .flag_en(flag_en),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v)
    );

    function automatic exp_t mk(input logic wr, input logic fe, input logic [31:0] r,
                                input logic c, input logic v);
        exp_t e;
        e.wr = wr; e.fe = fe; e.r = r; e.c = c; e.v = v;
        e.z = (r == 32'h0); e.n = r[31];
        return e;
    endfunction

    // Bit-serial reference model built from the requirements
    function automatic exp_t model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        logic c = 0, v = 0;
        logic wr, fe;
        int amt = int'(b[5:0]);
        wr = !(o == 4'h0 || o == 4'h1 || o == 4'h6 || o == 4'h7);
        fe = (o == 4'h0 || o == 4'h1 || o >= 4'h8);
        case (o)
            4'h0, 4'h8: begin
                r = a - b; c = (a < b);
                v = ($signed(a) < 0) != ($signed(b) < 0) && (r[31] != a[31]);
            end
            4'hA: begin
                r = a + b; c = (r < a);
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'h1, 4'h9: r = a & b;
            4'hB: r = a | b;
            4'hC: r = a ^ b;
            4'h2: r = b;
            4'h3: r = {{8{b[23]}}, b[23:0]};
            4'h4: r = b[20] ? {b[15:0], a[15:0]} : {a[31:16], b[15:0]};
            4'h5: begin
                r = a;
                for (int i = 0; i < int'(b[4:0]); i++) r = {r[30:0], r[31]};
            end
            4'hD: begin
                r = a;
                for (int i = 0; i < amt; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
                v = (amt != 0) && (r[31] != a[31]);
            end
            4'hE: begin
                r = a;
                for (int i = 0; i < amt; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
                v = (amt != 0) && (r[31] != a[31]);
            end
            4'hF: begin
                r = a;
                for (int i = 0; i < amt; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            end
            default: r = '0;
        endcase
        return mk(wr, fe, r, c, v);
    endfunction

    task automatic check1(input string req, input string what, input logic [31:0] act,
                          input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Drive one operation, sample one cycle later away from the edge
    task automatic apply(input string req, input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        check1(req, "out_valid", {31'b0, out_valid}, 32'h1);
        check1(req, "wr_en", {31'b0, wr_en}, {31'b0, e.wr});
        check1(req, "flag_en", {31'b0, flag_en}, {31'b0, e.fe});
        if (e.wr) check1(req, "result", result, e.r);
        if (e.fe) check1(req, "flags zcnv", {28'b0, flag_z, flag_c, flag_n, flag_v},
                         {28'b0, e.z, e.c, e.n, e.v});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check1("R1", "reset out_valid", {31'b0, out_valid}, 32'h0);
        check1("R1", "reset enables", {30'b0, wr_en, flag_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check1("R1", "idle out_valid", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic t_sub_cmp;
        apply("R3", 4'h8, 32'h80000000, 32'h1, mk(1, 1, 32'h7fffffff, 0, 1));
        apply("R3", 4'h0, 32'h5, 32'h5, mk(0, 1, 32'h0, 0, 0));
        apply("R5", 4'h0, 32'h1, 32'h2, mk(0, 1, 32'hffffffff, 1, 0));
        apply("R3", 4'hA, 32'h7fffffff, 32'h1, mk(1, 1, 32'h80000000, 0, 1));
        apply("R3", 4'hA, 32'hffffffff, 32'h1, mk(1, 1, 32'h0, 1, 0));
    endtask

    task automatic t_logic;
        apply("R4", 4'h1, 32'hf0, 32'h0f, mk(0, 1, 32'h0, 0, 0));
        apply("R4", 4'h9, 32'hff00ff00, 32'hf0f0f0f0, mk(1, 1, 32'hf000f000, 0, 0));
        apply("R4", 4'hB, 32'h0000ff00, 32'h000000ff, mk(1, 1, 32'h0000ffff, 0, 0));
        apply("R4", 4'hC, 32'h12345678, 32'h12345678, mk(1, 1, 32'h0, 0, 0));
    endtask

    task automatic t_shift_bounds;
        apply("R6", 4'hE, 32'h80000000, 32'h1, mk(1, 1, 32'h40000000, 0, 1));
        apply("R6", 4'hD, 32'h40000000, 32'h1, mk(1, 1, 32'h80000000, 0, 1));
        apply("R6", 4'hD, 32'h80000000, 32'h1, mk(1, 1, 32'h0, 1, 1));
        apply("R6", 4'hE, 32'h80000000, 32'd32, mk(1, 1, 32'h0, 1, 1));
        apply("R6", 4'hE, 32'h80000000, 32'd40, mk(1, 1, 32'h0, 0, 1));
        apply("R6", 4'hD, 32'h00000003, 32'd31, mk(1, 1, 32'h80000000, 1, 1));
        apply("R7", 4'hD, 32'h80000001, 32'h0, mk(1, 1, 32'h80000001, 0, 0));
        apply("R7", 4'hE, 32'h00000003, 32'h40, mk(1, 1, 32'h00000003, 0, 0));
        apply("R11", 4'hF, 32'h80000000, 32'd4, mk(1, 1, 32'hf8000000, 0, 0));
    endtask

    task automatic t_rotate;
        apply("R8", 4'h5, 32'h12345678, 32'd16, mk(1, 0, 32'h56781234, 0, 0));
        apply("R8", 4'h5, 32'h12345678, 32'h25, mk(1, 0, 32'h468acf02, 0, 0));
        apply("R8", 4'h5, 32'hdeadbeef, 32'h20, mk(1, 0, 32'hdeadbeef, 0, 0));
    endtask

    task automatic t_loads;
        apply("R9", 4'h3, 32'h0, 32'h00800001, mk(1, 0, 32'hff800001, 0, 0));
        apply("R9", 4'h3, 32'h0, 32'hff7fffff, mk(1, 0, 32'h007fffff, 0, 0));
        apply("R10", 4'h4, 32'haaaabbbb, 32'h00101234, mk(1, 0, 32'h1234bbbb, 0, 0));
        apply("R10", 4'h4, 32'haaaabbbb, 32'h00005678, mk(1, 0, 32'haaaa5678, 0, 0));
        apply("R11", 4'h2, 32'h11111111, 32'hcafef00d, mk(1, 0, 32'hcafef00d, 0, 0));
        apply("R2", 4'h6, 32'h1, 32'h1, mk(0, 0, 32'h0, 0, 0));
        apply("R2", 4'h7, 32'h1, 32'h1, mk(0, 0, 32'h0, 0, 0));
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [3:0]  o = 4'($urandom);
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            if (k % 3 == 0) a[31:30] = 2'($urandom);
            if (k % 4 == 0) begin
                int pick = int'($urandom % 6);
                b[5:0] = (pick == 0) ? 6'd0 : (pick == 1) ? 6'd1 : (pick == 2) ? 6'd31 :
                         (pick == 3) ? 6'd32 : (pick == 4) ? 6'd33 : 6'($urandom);
            end
            apply("R6 random (R2-R11 model)", o, a, b, model(o, a, b));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sub_cmp();
        t_logic();
        t_shift_bounds();
        t_rotate();
        t_loads();
        t_random();
        @(negedge clk);
        @(negedge clk);
        check1("R1", "drain out_valid", {31'b0, out_valid}, 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule